// File: doc/BRIEF.md
# Fetch-to-Memory Stage Latch with Program Counter

This block sits at the single boundary of a two-stage 32-bit processor pipeline. The first stage fetches, decodes, reads registers and runs the ALU. The second stage accesses data memory and writes a result back to the register file.

On every clock edge the block captures the first stage's side-effect control bits, its ALU result, its destination register index and its instruction word. The data-memory address seen by the second stage is taken from the captured ALU result.

The block also owns the program counter. The counter normally steps by 4 each cycle. It loads a branch or jump target when one is presented. It holds whenever fetch is stalled.

Two control inputs come from hazard logic outside the block:
- A flush turns the entry being captured into a true no-operation. All side-effect bits are cleared and the fixed NOP word is loaded.
- A stall freezes both the captured entry and the program counter.

Top module: `fm_pipe_latch`

## Requirements
- R1: While `rst_n` is low (asynchronously), all five side-effect outputs are 0, `m_instr_o` is 32'h0000000F, `m_alu_o` and `m_dest_o` are 0, and `pc_o` equals `RESET_PC` (default 0).
- R2: With `flush_i` and `stall_i` both low, each `m_*` output equals the matching `a_*` input sampled at the previous rising edge.
- R3: `dmem_addr_o` is the registered ALU result. It does not follow a change on `a_alu_i` until the next rising edge.
- R4: A rising edge with `flush_i` high makes `m_reg_wr_o`, `m_mem_wr_o`, `m_mem_rd_o`, `m_branch_o` and `m_jump_o` all 0. It also loads `m_instr_o` with 32'h0000000F (register-ALU group, secondary op 4'b1111, other bits 0) and clears `m_alu_o` and `m_dest_o`.
- R5: Flush takes priority over stall. With both high, the result is the R4 NOP entry.
- R6: A rising edge with `stall_i` high and `flush_i` low leaves every `m_*` output and `dmem_addr_o` unchanged.
- R7: A rising edge with `stall_i` high leaves `pc_o` unchanged, even when `redir_valid_i` is high.
- R8: A rising edge with `stall_i` and `redir_valid_i` low advances `pc_o` by 4.
- R9: A rising edge with `redir_valid_i` high and `stall_i` low loads `pc_o` with `redir_pc_i`.
- R10: A flush without a stall does not hold the program counter. `pc_o` still advances per R8 or R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| flush_i | input | 1 | Replace the captured entry with a NOP |
| stall_i | input | 1 | Hold captured entry and program counter |
| redir_valid_i | input | 1 | Branch/jump target is valid this cycle |
| redir_pc_i | input | AW (32) | Branch/jump target address |
| a_reg_wr_i | input | 1 | First-stage register-write enable |
| a_mem_wr_i | input | 1 | First-stage memory-write enable |
| a_mem_rd_i | input | 1 | First-stage memory-read enable |
| a_branch_i | input | 1 | First-stage branch indicator |
| a_jump_i | input | 1 | First-stage jump indicator |
| a_alu_i | input | DW (32) | Combinational ALU result |
| a_dest_i | input | RW (5) | Destination register index |
| a_instr_i | input | 32 | Instruction word |
| pc_o | output | AW (32) | Current program counter (fetch address) |
| m_reg_wr_o | output | 1 | Captured register-write enable |
| m_mem_wr_o | output | 1 | Captured memory-write enable |
| m_mem_rd_o | output | 1 | Captured memory-read enable |
| m_branch_o | output | 1 | Captured branch indicator |
| m_jump_o | output | 1 | Captured jump indicator |
| m_alu_o | output | DW (32) | Captured ALU result |
| m_dest_o | output | RW (5) | Captured destination index |
| m_instr_o | output | 32 | Captured instruction word |
| dmem_addr_o | output | DW (32) | Data-memory address for the second stage |

## Verification
The hardest case to reach is a stall and a flush that overlap while a redirect is also pending. The latch must then take the NOP while the program counter ignores the target.

The stimulus first loads a fully active entry, with every side-effect bit set, so that clearing is visible. It then raises flush, stall and a redirect together for one edge. Finally it checks that the NOP appeared, that `pc_o` did not move, and that the next unstalled edge resumes stepping.

// File: rtl/fm_pipe_pkg.sv
package fm_pipe_pkg;
  localparam int INSTR_W = 32;
  localparam logic [INSTR_W-1:0] NOP_WORD = 32'h0000_000F;

  typedef struct packed {
    logic reg_wr;
    logic mem_wr;
    logic mem_rd;
    logic is_branch;
    logic is_jump;
  } side_fx_t;

  localparam int FX_W = $bits(side_fx_t);
endpackage

// File: rtl/fm_hold_reg.sv
// Pipeline register slice: flush loads FLUSH_VAL, stall holds, else capture.
module fm_hold_reg #(
  parameter int           W         = 8,
  parameter logic [W-1:0] RST_VAL   = '0,
  parameter logic [W-1:0] FLUSH_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         stall,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (flush)       q_nxt = FLUSH_VAL;
    else if (!stall) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/fm_pc_reg.sv
// Program counter: stall holds, redirect loads target, else step.
module fm_pc_reg #(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0,
  parameter int            STEP     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          redir_valid,
  input  logic [AW-1:0] redir_pc,
  output logic [AW-1:0] pc
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] pc_nxt;
  logic          pc_en;

  assign pc_en = !stall;

  always_comb begin
    pc_nxt = pc + STEP_V;
    if (redir_valid) pc_nxt = redir_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc <= RESET_PC;
    else if (pc_en) pc <= pc_nxt;
  end
endmodule

// File: rtl/fm_pipe_latch.sv
module fm_pipe_latch
  import fm_pipe_pkg::*;
#(
  parameter int            AW       = 32,
  parameter int            DW       = 32,
  parameter int            RW       = 5,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush_i,
  input  logic               stall_i,
  input  logic               redir_valid_i,
  input  logic [AW-1:0]      redir_pc_i,
  input  logic               a_reg_wr_i,
  input  logic               a_mem_wr_i,
  input  logic               a_mem_rd_i,
  input  logic               a_branch_i,
  input  logic               a_jump_i,
  input  logic [DW-1:0]      a_alu_i,
  input  logic [RW-1:0]      a_dest_i,
  input  logic [INSTR_W-1:0] a_instr_i,
  output logic [AW-1:0]      pc_o,
  output logic               m_reg_wr_o,
  output logic               m_mem_wr_o,
  output logic               m_mem_rd_o,
  output logic               m_branch_o,
  output logic               m_jump_o,
  output logic [DW-1:0]      m_alu_o,
  output logic [RW-1:0]      m_dest_o,
  output logic [INSTR_W-1:0] m_instr_o,
  output logic [DW-1:0]      dmem_addr_o
);
  side_fx_t fx_a, fx_m;

  always_comb begin
    fx_a.reg_wr    = a_reg_wr_i;
    fx_a.mem_wr    = a_mem_wr_i;
    fx_a.mem_rd    = a_mem_rd_i;
    fx_a.is_branch = a_branch_i;
    fx_a.is_jump   = a_jump_i;
  end

  fm_hold_reg #(.W(FX_W), .RST_VAL('0), .FLUSH_VAL('0)) fx_reg_i (
    .clk(clk), .rst_n(rst_n), .flush(flush_i), .stall(stall_i),
    .d(fx_a), .q(fx_m)
  );

  fm_hold_reg #(.W(DW), .RST_VAL('0), .FLUSH_VAL('0)) alu_reg_i (
    .clk(clk), .rst_n(rst_n), .flush(flush_i), .stall(stall_i),
    .d(a_alu_i), .q(m_alu_o)
  );

  fm_hold_reg #(.W(RW), .RST_VAL('0), .FLUSH_VAL('0)) dest_reg_i (
    .clk(clk), .rst_n(rst_n), .flush(flush_i), .stall(stall_i),
    .d(a_dest_i), .q(m_dest_o)
  );

  fm_hold_reg #(.W(INSTR_W), .RST_VAL(NOP_WORD), .FLUSH_VAL(NOP_WORD)) ins_reg_i (
    .clk(clk), .rst_n(rst_n), .flush(flush_i), .stall(stall_i),
    .d(a_instr_i), .q(m_instr_o)
  );

  fm_pc_reg #(.AW(AW), .RESET_PC(RESET_PC), .STEP(4)) pc_reg_i (
    .clk(clk), .rst_n(rst_n), .stall(stall_i),
    .redir_valid(redir_valid_i), .redir_pc(redir_pc_i), .pc(pc_o)
  );

  assign m_reg_wr_o  = fx_m.reg_wr;
  assign m_mem_wr_o  = fx_m.mem_wr;
  assign m_mem_rd_o  = fx_m.mem_rd;
  assign m_branch_o  = fx_m.is_branch;
  assign m_jump_o    = fx_m.is_jump;
  // Second-stage memory address comes from the registered result only.
  assign dmem_addr_o = m_alu_o;
endmodule

// File: rtl/fm_pipe_latch_chk.sv
module fm_pipe_latch_chk #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush_i,
  input logic          stall_i,
  input logic          redir_valid_i,
  input logic [AW-1:0] redir_pc_i,
  input logic [DW-1:0] a_alu_i,
  input logic [RW-1:0] a_dest_i,
  input logic [AW-1:0] pc_o,
  input logic          m_reg_wr_o,
  input logic          m_mem_wr_o,
  input logic          m_mem_rd_o,
  input logic          m_branch_o,
  input logic          m_jump_o,
  input logic [DW-1:0] m_alu_o,
  input logic [RW-1:0] m_dest_o,
  input logic [31:0]   m_instr_o,
  input logic [DW-1:0] dmem_addr_o
);
  AST_CAPTURE_ALU: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && !stall_i) |=> (m_alu_o == $past(a_alu_i) && m_dest_o == $past(a_dest_i))); // R2

  AST_FLUSH_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!m_reg_wr_o && !m_mem_wr_o && !m_mem_rd_o && !m_branch_o && !m_jump_o
                 && m_instr_o == 32'h0000000F)); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !flush_i) |=> ($stable(m_instr_o) && $stable(dmem_addr_o) && $stable(m_reg_wr_o))); // R6

  AST_PC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(pc_o)); // R7

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && !redir_valid_i) |=> (pc_o == $past(pc_o) + AW'(4))); // R8

  AST_PC_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall_i && redir_valid_i) |=> (pc_o == $past(redir_pc_i))); // R9
endmodule

bind fm_pipe_latch fm_pipe_latch_chk #(.AW(AW), .DW(DW), .RW(RW)) chk_i (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .stall_i(stall_i),
  .redir_valid_i(redir_valid_i), .redir_pc_i(redir_pc_i),
  .a_alu_i(a_alu_i), .a_dest_i(a_dest_i), .pc_o(pc_o),
  .m_reg_wr_o(m_reg_wr_o), .m_mem_wr_o(m_mem_wr_o), .m_mem_rd_o(m_mem_rd_o),
  .m_branch_o(m_branch_o), .m_jump_o(m_jump_o), .m_alu_o(m_alu_o),
  .m_dest_o(m_dest_o), .m_instr_o(m_instr_o), .dmem_addr_o(dmem_addr_o)
);

// File: tb/fm_pipe_latch_tb_top.sv
module fm_pipe_latch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] NOP = 32'h0000000F;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        flush_i, stall_i, redir_valid_i;
  logic [31:0] redir_pc_i;
  logic        a_reg_wr_i, a_mem_wr_i, a_mem_rd_i, a_branch_i, a_jump_i;
  logic [31:0] a_alu_i;
  logic [4:0]  a_dest_i;
  logic [31:0] a_instr_i;
  logic [31:0] pc_o;
  logic        m_reg_wr_o, m_mem_wr_o, m_mem_rd_o, m_branch_o, m_jump_o;
  logic [31:0] m_alu_o;
  logic [4:0]  m_dest_o;
  logic [31:0] m_instr_o;
  logic [31:0] dmem_addr_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fm_pipe_latch dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .stall_i(stall_i),
    .redir_valid_i(redir_valid_i), .redir_pc_i(redir_pc_i),
    .a_reg_wr_i(a_reg_wr_i), .a_mem_wr_i(a_mem_wr_i), .a_mem_rd_i(a_mem_rd_i),
    .a_branch_i(a_branch_i), .a_jump_i(a_jump_i), .a_alu_i(a_alu_i),
    .a_dest_i(a_dest_i), .a_instr_i(a_instr_i), .pc_o(pc_o),
    .m_reg_wr_o(m_reg_wr_o), .m_mem_wr_o(m_mem_wr_o), .m_mem_rd_o(m_mem_rd_o),
    .m_branch_o(m_branch_o), .m_jump_o(m_jump_o), .m_alu_o(m_alu_o),
    .m_dest_o(m_dest_o), .m_instr_o(m_instr_o), .dmem_addr_o(dmem_addr_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] fx_bits();
    return {27'd0, m_reg_wr_o, m_mem_wr_o, m_mem_rd_o, m_branch_o, m_jump_o};
  endfunction

  task automatic set_a(input logic [4:0] fx, input logic [31:0] alu,
                       input logic [4:0] dst, input logic [31:0] ins);
    {a_reg_wr_i, a_mem_wr_i, a_mem_rd_i, a_branch_i, a_jump_i} = fx;
    a_alu_i = alu; a_dest_i = dst; a_instr_i = ins;
  endtask

  task automatic edge_step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0;
    #1;
    chk("R1 fx", fx_bits(), 32'd0);
    chk("R1 instr", m_instr_o, NOP);
    chk("R1 alu", m_alu_o, 32'd0);
    chk("R1 dest", {27'd0, m_dest_o}, 32'd0);
    chk("R1 pc", pc_o, 32'd0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_capture(input logic [4:0] fx, input logic [31:0] alu,
                           input logic [4:0] dst, input logic [31:0] ins);
    @(negedge clk);
    flush_i = 0; stall_i = 0; redir_valid_i = 0;
    set_a(fx, alu, dst, ins);
    edge_step();
    chk("R2 fx", fx_bits(), {27'd0, fx});
    chk("R2 alu", m_alu_o, alu);
    chk("R2 dest", {27'd0, m_dest_o}, {27'd0, dst});
    chk("R2 instr", m_instr_o, ins);
  endtask

  task automatic t_addr();
    logic [31:0] old;
    t_capture(5'b00100, 32'h0000_0040, 5'd3, 32'h1234_5678);
    old = dmem_addr_o;
    @(negedge clk);
    a_alu_i = 32'h0000_0080;
    #1;
    chk("R3 before edge", dmem_addr_o, old);
    edge_step();
    chk("R3 after edge", dmem_addr_o, 32'h0000_0080);
  endtask

  task automatic t_flush();
    logic [31:0] pc0;
    @(negedge clk);
    set_a(5'b11111, 32'hDEAD_BEEF, 5'd31, 32'hFFFF_FFFF);
    flush_i = 1; stall_i = 0; redir_valid_i = 0;
    pc0 = pc_o;
    edge_step();
    chk("R4 fx", fx_bits(), 32'd0);
    chk("R4 instr", m_instr_o, NOP);
    chk("R4 alu", m_alu_o, 32'd0);
    chk("R4 dest", {27'd0, m_dest_o}, 32'd0);
    chk("R10 pc", pc_o, pc0 + 32'd4);
    @(negedge clk); flush_i = 0;
  endtask

  task automatic t_flush_stall();
    logic [31:0] pc0;
    t_capture(5'b11111, 32'h5555_AAAA, 5'd9, 32'h0ABC_DEF0);
    @(negedge clk);
    flush_i = 1; stall_i = 1; redir_valid_i = 1; redir_pc_i = 32'h0000_2000;
    pc0 = pc_o;
    edge_step();
    chk("R5 fx", fx_bits(), 32'd0);
    chk("R5 instr", m_instr_o, NOP);
    chk("R7 pc during flush+stall", pc_o, pc0);
    @(negedge clk); flush_i = 0; stall_i = 0; redir_valid_i = 0;
    edge_step();
    chk("R8 resume", pc_o, pc0 + 32'd4);
  endtask

  task automatic t_stall();
    logic [31:0] pc0;
    t_capture(5'b10101, 32'h1357_9BDF, 5'd17, 32'h2468_ACE0);
    @(negedge clk);
    stall_i = 1; redir_valid_i = 1; redir_pc_i = 32'h0000_3000;
    set_a(5'b01010, 32'h0, 5'd2, 32'h0);
    pc0 = pc_o;
    for (int i = 0; i < 2; i++) begin
      edge_step();
      chk("R6 fx", fx_bits(), 32'h15);
      chk("R6 addr", dmem_addr_o, 32'h1357_9BDF);
      chk("R6 instr", m_instr_o, 32'h2468_ACE0);
      chk("R7 pc", pc_o, pc0);
    end
    @(negedge clk); stall_i = 0; redir_valid_i = 0;
  endtask

  task automatic t_step();
    logic [31:0] pc0;
    @(negedge clk);
    flush_i = 0; stall_i = 0; redir_valid_i = 0;
    pc0 = pc_o;
    for (int i = 1; i <= 3; i++) begin
      edge_step();
      chk("R8 step", pc_o, pc0 + 32'(4 * i));
    end
  endtask

  task automatic t_redirect();
    @(negedge clk);
    redir_valid_i = 1; redir_pc_i = 32'h0000_1000; stall_i = 0;
    edge_step();
    chk("R9 target", pc_o, 32'h0000_1000);
    @(negedge clk); redir_valid_i = 0;
    edge_step();
    chk("R8 after target", pc_o, 32'h0000_1004);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    report();
  end

  initial begin
    rst_n = 1'b0; flush_i = 0; stall_i = 0; redir_valid_i = 0; redir_pc_i = '0;
    set_a(5'b0, '0, '0, '0);
    repeat (2) @(posedge clk);
    t_reset();
    t_capture(5'b11111, 32'hA5A5_5A5A, 5'd21, 32'h0123_4567);
    t_capture(5'b01010, 32'h0000_FFFC, 5'd1, 32'h8000_0001);
    t_addr();
    t_flush();
    t_flush_stall();
    t_stall();
    t_step();
    t_redirect();
    t_reset();
    report();
  end
endmodule